// File: doc/BRIEF.md
# Eight-Channel Double-Buffered Converter Register Front End

This block is the digital front end of an eight-channel, 14-bit digital-to-analog converter. It models its two register stages synchronously on a system clock. A processor writes one channel at a time over a parallel bus. The bus has an active-low select, an active-low write strobe, a 3-bit channel address and a 14-bit data word. The written word lands in that channel's input register.

A single active-low load line is shared by all channels. While it is low, every channel's output register follows its input register, so all eight outputs change on the same clock edge. If select, write and load are all low together, a bus word reaches the addressed channel's output in the same cycle it is written.

An active-low clear line overrides every output code with the mid-scale ground code and raises a flag while it is asserted. The stored registers are not changed, so the previous codes come back when clear is released. Codes are offset binary. A mode input lets the processor write two's complement words instead, and these are converted as they are stored.

Top module: `octal_dac_frontend`

## Requirements
- R1: A synchronous active-high reset sets every input and output register to the mid-scale code 0x2000 and clears the clear-active flag. One cycle after reset, all eight output codes read 0x2000 and the flag reads 0.
- R2: On a clock edge where sel_n and wr_n are both low, the input register of the addressed channel takes the bus word. Address 0 selects channel 0 (A), and the order rises to address 7 for channel 7 (H). Channel k occupies bits [14k+13:14k] of ch_code.
- R3: On an edge where sel_n or wr_n is high, no input register changes, whatever the bus and address carry.
- R4: On an edge where load_n is low, every channel's output register takes its input register's value, including any word written on that same edge. On an edge where load_n is high, no output register changes.
- R5: When sel_n, wr_n and load_n are all low on an edge, the addressed channel's output code equals the bus word after that edge. No separate load cycle is needed.
- R6: After an edge where clear_n is low, all eight output codes read 0x2000 and clr_active reads 1. After an edge where clear_n is high, clr_active reads 0.
- R7: Clear changes neither register stage. Writes and loads made while clear is asserted still take effect, and the codes held in the output registers appear once clear is released.
- R8: With twos_mode = 1, a written word is stored with bit 13 inverted, which converts two's complement to offset binary. With twos_mode = 0, the word is stored unchanged.
- R9: A write changes only the addressed channel. The other seven input registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Channel address for writes |
| data | input | 14 | Write data word |
| twos_mode | input | 1 | 1: data is two's complement; 0: offset binary |
| load_n | input | 1 | Active-low global load, shared by all channels |
| clear_n | input | 1 | Active-low output clear |
| ch_code | output | 112 | Eight effective 14-bit output codes, channel k at [14k+13:14k] |
| clr_active | output | 1 | High while the clear override is in force |

## Verification
Directed patterns separate the three behaviours of the load line. Writes made with load held high must leave every output unchanged, while one later load pulse must move all eight channels at once. Writes made with load held low must show through on the next edge, which separates write-through from a missed transfer. Bus activity with select or write high is followed by a load, which shows whether an input register was disturbed. A write into every channel in turn, each with a distinct value, catches address-decode swaps. Clear is held across writes and loads and then released, which shows whether it overrode only the outputs or also touched storage. Random cycles with mixed strobes, both data formats and sporadic clears are compared every cycle against a bench reference model.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    // Data format selected by the twos_mode pin.
    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } data_fmt_e;

    // Decoded active-high strobes for one clock cycle.
    typedef struct packed {
        logic wr_en;
        logic ld_en;
        logic clr_en;
    } strobe_t;

    function automatic strobe_t decode_strobes(
        input logic sel_n,
        input logic wr_n,
        input logic load_n,
        input logic clear_n
    );
        strobe_t s;
        s.wr_en  = ~sel_n & ~wr_n;
        s.ld_en  = ~load_n;
        s.clr_en = ~clear_n;
        return s;
    endfunction

endpackage

// File: rtl/dac_fe_inreg.sv
module dac_fe_inreg
    import dac_fe_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              data,
    input  data_fmt_e                      fmt,
    output logic [NUM_CH-1:0][DATA_W-1:0]  in_d,
    output logic [NUM_CH-1:0][DATA_W-1:0]  in_q
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic [NUM_CH-1:0] hit;
    logic [DATA_W-1:0] conv_word;

    // One address comparator per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_decode
        assign hit[ch] = wr_en && (addr == ADDR_W'(ch));
    end

    always_comb begin
        // Two's complement to offset binary: invert the sign bit.
        conv_word = (fmt == FMT_TWOS) ? (data ^ MID_CODE) : data;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            in_d[ch] = hit[ch] ? conv_word : in_q[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                in_q[ch] <= MID_CODE;
            end
        end else begin
            in_q <= in_d;
        end
    end

endmodule

// File: rtl/dac_fe_dacreg.sv
module dac_fe_dacreg #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  src_d,
    output logic [NUM_CH-1:0][DATA_W-1:0]  dac_q
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic [NUM_CH-1:0][DATA_W-1:0] dac_d;

    // The next input-register value is the source, so a word written on a
    // load edge reaches the output register on that same edge.
    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            dac_d[ch] = ld_en ? src_d[ch] : dac_q[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                dac_q[ch] <= MID_CODE;
            end
        end else begin
            dac_q <= dac_d;
        end
    end

endmodule

// File: rtl/dac_fe_outmux.sv
module dac_fe_outmux #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  dac_q,
    output logic [NUM_CH*DATA_W-1:0]       code_out,
    output logic                           clr_q
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic clr_d;

    always_comb begin
        clr_d = clr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= clr_d;
        end
    end

    // Override per channel; the stored code is untouched.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ovr
        assign code_out[ch*DATA_W +: DATA_W] = clr_q ? MID_CODE : dac_q[ch];
    end

endmodule

// File: rtl/octal_dac_frontend.sv
module octal_dac_frontend
    import dac_fe_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14,
    localparam int unsigned ADDR_W = $clog2(NUM_CH),
    localparam int unsigned BUS_W  = NUM_CH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              twos_mode,
    input  logic              load_n,
    input  logic              clear_n,
    output logic [BUS_W-1:0]  ch_code,
    output logic              clr_active
);

    strobe_t   stb;
    data_fmt_e fmt;

    logic [NUM_CH-1:0][DATA_W-1:0] in_d;
    logic [NUM_CH-1:0][DATA_W-1:0] in_q;
    logic [NUM_CH-1:0][DATA_W-1:0] dac_q;

    always_comb begin
        stb = decode_strobes(sel_n, wr_n, load_n, clear_n);
        fmt = twos_mode ? FMT_TWOS : FMT_OFFSET;
    end

    dac_fe_inreg #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_inreg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (stb.wr_en),
        .addr  (addr),
        .data  (data),
        .fmt   (fmt),
        .in_d  (in_d),
        .in_q  (in_q)
    );

    dac_fe_dacreg #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_dacreg (
        .clk   (clk),
        .rst   (rst),
        .ld_en (stb.ld_en),
        .src_d (in_d),
        .dac_q (dac_q)
    );

    dac_fe_outmux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_outmux (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (stb.clr_en),
        .dac_q    (dac_q),
        .code_out (ch_code),
        .clr_q    (clr_active)
    );

endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14,
    parameter int unsigned ADDR_W = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sel_n,
    input logic                       wr_n,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          data,
    input logic                       twos_mode,
    input logic                       load_n,
    input logic                       clear_n,
    input logic [NUM_CH*DATA_W-1:0]   ch_code,
    input logic                       clr_active
);

    localparam logic [DATA_W-1:0]        MID_CODE = DATA_W'(1) << (DATA_W - 1);
    localparam logic [NUM_CH*DATA_W-1:0] ALL_MID  = {NUM_CH{MID_CODE}};

    // Becomes 1 once a full clock has passed after reset, so $past and
    // $stable never see values from before reset.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R1: the cycle after reset shows mid-scale everywhere and no clear
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (ch_code == ALL_MID) && !clr_active);

    // R6: clear override forces mid-scale on every channel
    assert_clear_forces_mid_R6: assert property (@(posedge clk) disable iff (rst)
        clr_active |-> ch_code == ALL_MID);

    // R6: clear flag follows the sampled clear line
    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        clr_active == !$past(clear_n));

    // R4: with load high and no clear on either side, outputs hold
    assert_load_high_holds_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(load_n) && !clr_active && !$past(clr_active) |-> $stable(ch_code));

    // R5: write-through when select, write and load are low together
    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(sel_n) && !$past(wr_n) && !$past(load_n) && !clr_active |->
        ch_code[$past(addr)*DATA_W +: DATA_W] ==
            ($past(twos_mode) ? ($past(data) ^ MID_CODE) : $past(data)));

endmodule

bind octal_dac_frontend dac_fe_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .data       (data),
    .twos_mode  (twos_mode),
    .load_n     (load_n),
    .clear_n    (clear_n),
    .ch_code    (ch_code),
    .clr_active (clr_active)
);

// File: tb/tb_octal_dac_frontend.sv
`timescale 1ns/1ps
module tb_octal_dac_frontend;

    localparam int NCH = 8;
    localparam int DW  = 14;
    localparam logic [DW-1:0] MID = 14'h2000;

    logic              clk = 1'b0;
    logic              rst;
    logic              sel_n, wr_n, twos_mode, load_n, clear_n;
    logic [2:0]        addr;
    logic [DW-1:0]     data;
    logic [NCH*DW-1:0] ch_code;
    logic              clr_active;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic [DW-1:0] m_in  [NCH];
    logic [DW-1:0] m_dac [NCH];
    logic          m_clr;

    always #5 clk = ~clk;

    octal_dac_frontend dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
        .data(data), .twos_mode(twos_mode), .load_n(load_n),
        .clear_n(clear_n), .ch_code(ch_code), .clr_active(clr_active)
    );

    function automatic logic [DW-1:0] stored_word(logic [DW-1:0] d, logic tc);
        return tc ? (d ^ MID) : d;
    endfunction

    function automatic logic [DW-1:0] exp_code(int ch);
        return m_clr ? MID : m_dac[ch];
    endfunction

    // Reference model update for one edge.
    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_in[i]  = MID;
                m_dac[i] = MID;
            end
            m_clr = 1'b0;
        end else begin
            if (!sel_n && !wr_n) m_in[addr] = stored_word(data, twos_mode);
            if (!load_n) begin
                for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
            end
            m_clr = !clear_n;
        end
    endtask

    task automatic check_all(string req);
        compared++;
        if (clr_active !== m_clr) begin
            mismatched++;
            $display("FAIL %s clr_active actual=%0b expected=%0b", req, clr_active, m_clr);
        end
        for (int i = 0; i < NCH; i++) begin
            compared++;
            if (ch_code[i*DW +: DW] !== exp_code(i)) begin
                mismatched++;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, i,
                         ch_code[i*DW +: DW], exp_code(i));
            end
        end
    endtask

    // Drive inputs at the falling edge, clock once, check at the next fall.
    task automatic cycle(logic s, logic w, logic [2:0] a, logic [DW-1:0] d,
                         logic tc, logic l, logic c, string req);
        sel_n = s; wr_n = w; addr = a; data = d; twos_mode = tc;
        load_n = l; clear_n = c;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sel_n = 1; wr_n = 1; addr = 0; data = 0;
        twos_mode = 0; load_n = 1; clear_n = 1;
        @(negedge clk);
        @(posedge clk); model_edge();
        @(negedge clk);
        rst = 1'b0;
        check_all("R1_reset");

        // R2/R9: write all channels with load held high: outputs stay put
        for (int i = 0; i < NCH; i++)
            cycle(0, 0, 3'(i), 14'(16'h0100 * (i + 1) + i), 0, 1, 1, "R2_write_no_load");
        // R4: one load moves all channels
        cycle(1, 1, 0, 14'h3FFF, 0, 0, 1, "R4_global_load");
        // R3: bus activity with select or write high is ignored
        cycle(1, 0, 3'd2, 14'h1111, 0, 1, 1, "R3_sel_high");
        cycle(0, 1, 3'd5, 14'h2222, 0, 1, 1, "R3_wr_high");
        cycle(1, 1, 3'd0, 14'h0000, 0, 0, 1, "R3_load_after_ignored");
        // R5: write-through
        cycle(0, 0, 3'd7, 14'h3FFF, 0, 0, 1, "R5_write_through_H");
        cycle(0, 0, 3'd0, 14'h0000, 0, 0, 1, "R5_write_through_A");
        // R8: two's complement mode
        cycle(0, 0, 3'd3, 14'h0000, 1, 0, 1, "R8_twos_zero");
        cycle(0, 0, 3'd4, 14'h3FFF, 1, 0, 1, "R8_twos_minus1");
        cycle(0, 0, 3'd4, 14'h1FFF, 0, 0, 1, "R8_offset_plain");
        // R6/R7: clear overrides, writes and loads continue underneath
        cycle(1, 1, 0, 0, 0, 1, 0, "R6_clear_on");
        cycle(0, 0, 3'd6, 14'h0ABC, 0, 1, 0, "R7_write_in_clear");
        cycle(1, 1, 0, 0, 0, 0, 0, "R7_load_in_clear");
        cycle(1, 1, 0, 0, 0, 1, 1, "R7_clear_release");
        cycle(1, 1, 0, 0, 0, 1, 1, "R6_clear_off_hold");

        // Random mix, all requirements, with R9 isolation checked each cycle
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] & r[1], r[2] & r[3], 3'($urandom_range(0, 7)),
                  14'($urandom), r[4], r[5] | r[6], ~(r[7] & r[8] & r[9]),
                  "R9_random");
        end

        // R1: reset again mid-run
        rst = 1'b1;
        @(posedge clk); model_edge();
        @(negedge clk);
        rst = 1'b0;
        check_all("R1_reset_again");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule